// File: doc/BRIEF.md
# Three-Level Descriptor Table Walker

This block turns a 32-bit virtual address into a physical address. It walks descriptor tables that sit in ordinary memory. A core presents a virtual address, a read/write flag and a supervisor flag. The walker then fetches a two-word level-A entry from the root table. After that it fetches a one-word level-B entry and a one-word level-C entry, stopping earlier if an entry already describes a page. It answers with a one-cycle done pulse that carries the physical address, a cache-inhibit attribute and a fault code.

The virtual address is split at fixed bit positions:

| Virtual address bits | Use |
|---|---|
| 31:25 | level-A index |
| 24:18 | level-B index |
| 17:12 | level-C index |
| 11:0 | byte offset |

Every descriptor carries a 2-bit type code in bits 1:0, with these encodings:

| Code | Meaning |
|---|---|
| 00 | invalid |
| 01 | page |
| 10 | short table pointer |
| 11 | long table pointer |

The walker also keeps the descriptors' status bits in memory up to date. On the way down it sets the used bit of every entry it passes through. On a write it sets the modified bit of the page entry it reaches. Both updates go out on the same simple 32-bit memory port that it uses for fetches.

Top module: `mmu_table_walker`

## Requirements
- R1: While reset is held and on the first cycle after it, `resp_done` and `mem_req` are low, and `req_ready` is high once reset is released.
- R2: The first fetch of a walk reads word 0 of the level-A entry at `(root_base & 0xFFFFFFF0) + va[31:25]*8`. The second fetch reads word 1 at that address plus 4.
- R3: A walk through all three levels returns `resp_paddr = (C word & 0xFFFFFF00) + va[11:0]` with fault code 00. `resp_ci` equals bit 6 of the level-C word.
- R4: A level-A entry of type 01 ends the walk after two reads. The walk returns `(word1 & 0xFFFFFF00) + va[24:0]`, and `resp_ci` equals bit 6 of word 0.
- R5: A level-B entry of type 01 ends the walk after three reads and returns `(B word & 0xFFFFFF00) + va[17:0]`.
- R6: The walk ends with fault code 01 (invalid) in any of these cases: type 00 at any level, type 11 at any level, or type 10 at level C. Any fault reports `resp_paddr = 0` and `resp_ci = 0`.
- R7: On a write access, a descriptor on the path with bit 2 set ends the walk with fault code 10 (write-protect). On a read access, bit 2 has no effect.
- R8: A level-A entry with bit 8 set, reached by a user access (`req_super = 0`), ends the walk with fault code 11 (privilege). When more than one fault applies, invalid wins over privilege, and privilege wins over write-protect.
- R9: A non-faulting descriptor whose bit 3 (used) is clear is written back once with bit 3 set and all other bits unchanged. For level A this is word 0 at the entry address. A descriptor that already has bit 3 set is not written.
- R10: A write access that reaches a page descriptor with bit 4 (modified) clear sets bits 3 and 4 together in a single write-back. A read access leaves bit 4 as it is.
- R11: The descriptor that raises a fault is never written back.
- R12: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` are held steady. `resp_done` is high for exactly one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_base | input | 32 | Physical base of the root table (low 4 bits ignored) |
| req_valid | input | 1 | Translation request, accepted when `req_ready` is high |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access |
| req_super | input | 1 | 1 for a supervisor access |
| resp_done | output | 1 | One-cycle pulse ending a walk |
| resp_paddr | output | 32 | Physical address, 0 on fault |
| resp_fault | output | 2 | Fault code: 00 none, 01 invalid, 10 write-protect, 11 privilege |
| resp_ci | output | 1 | Cache-inhibit bit of the page descriptor |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a descriptor write-back |
| mem_addr | output | 32 | Byte address of the descriptor word |
| mem_wdata | output | 32 | Updated descriptor word |
| mem_rdata | input | 32 | Fetched descriptor word, valid with `mem_ack` |
| mem_ack | input | 1 | Access completed |

## Verification
Two status changes can land on the same descriptor in the same decision cycle. A write access can reach a page entry whose used and modified bits are both clear, and both updates must then leave in one write-back rather than two. The bench builds a fresh chain with every status bit clear and runs a write through it. It counts the memory writes of that walk (three expected, one per level) and reads back the page word with both bits set. A second identical write must then produce no memory writes at all.

// File: rtl/mmu_walk_pkg.sv
// Shared encodings for the descriptor table walker.
// Assumes 32-bit descriptor words with the type code in bits 1:0.
package mmu_walk_pkg;

    typedef enum logic [1:0] {
        DT_INVALID   = 2'b00,
        DT_PAGE      = 2'b01,
        DT_SHORT_TBL = 2'b10,
        DT_LONG_TBL  = 2'b11
    } desc_type_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_INVALID = 2'b01,
        FLT_WPROT   = 2'b10,
        FLT_PRIV    = 2'b11
    } fault_e;

    typedef enum logic [1:0] {
        LVL_A = 2'd0,
        LVL_B = 2'd1,
        LVL_C = 2'd2
    } level_e;

    typedef enum logic [1:0] {
        RES_NEXT  = 2'd0,
        RES_PAGE  = 2'd1,
        RES_FAULT = 2'd2
    } result_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_A0    = 3'd1,
        ST_RD_A1    = 3'd2,
        ST_RD_SHORT = 3'd3,
        ST_WRBACK   = 3'd4,
        ST_ADVANCE  = 3'd5
    } walk_state_e;

    // Attribute bit positions shared by all descriptor formats
    localparam int POS_WP    = 2;
    localparam int POS_USED  = 3;
    localparam int POS_MOD   = 4;
    localparam int POS_CI    = 6;
    localparam int POS_SUPER = 8;

endpackage

// File: rtl/mmu_desc_decode.sv
// Classifies one descriptor attribute word: next level, page end or fault.
// It also forms the write-back word carrying the updated used/modified bits.
// Purely combinational. Assumes the caller presents the word for the given level.
module mmu_desc_decode
    import mmu_walk_pkg::*;
(
    input  logic [31:0] attr,
    input  level_e      lvl,
    input  logic        is_write,
    input  logic        is_super,
    output result_e     res,
    output fault_e      flt,
    output logic        need_wb,
    output logic [31:0] wb_word,
    output logic        ci
);

    desc_type_e dt;
    logic       is_page;
    logic       bad_type;
    logic       priv_hit;
    logic       wp_hit;
    logic       set_mod;

    // Decode type, check protection and compute the updated status word
    always_comb begin
        dt       = desc_type_e'(attr[1:0]);
        is_page  = (dt == DT_PAGE);
        bad_type = (dt == DT_INVALID) || (dt == DT_LONG_TBL) ||
                   ((lvl == LVL_C) && (dt == DT_SHORT_TBL));
        priv_hit = (lvl == LVL_A) && attr[POS_SUPER] && !is_super;
        wp_hit   = attr[POS_WP] && is_write;

        if (bad_type)      flt = FLT_INVALID;
        else if (priv_hit) flt = FLT_PRIV;
        else if (wp_hit)   flt = FLT_WPROT;
        else               flt = FLT_NONE;

        if (flt != FLT_NONE) res = RES_FAULT;
        else if (is_page)    res = RES_PAGE;
        else                 res = RES_NEXT;

        set_mod = is_page && is_write && !attr[POS_MOD];
        wb_word = attr;
        wb_word[POS_USED] = 1'b1;
        if (set_mod) wb_word[POS_MOD] = 1'b1;

        need_wb = (flt == FLT_NONE) && (wb_word != attr);
        ci      = is_page && attr[POS_CI];
    end

endmodule

// File: rtl/mmu_addr_gen.sv
// Address arithmetic for the walk: the entry address within a table and the
// final physical address from a page base plus the level's offset.
// Assumes long entries are 8 bytes (level A) and short entries are 4 bytes.
module mmu_addr_gen
    import mmu_walk_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IDX_A_W = 7,
    parameter int IDX_B_W = 7,
    parameter int IDX_C_W = 6
) (
    input  level_e            ent_lvl,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [ADDR_W-1:0] va,
    input  level_e            pg_lvl,
    input  logic [ADDR_W-1:0] pg_base,
    output logic [ADDR_W-1:0] ent_addr,
    output logic [ADDR_W-1:0] page_addr
);

    localparam int A_LO = ADDR_W - IDX_A_W;
    localparam int B_LO = A_LO - IDX_B_W;
    localparam int C_LO = B_LO - IDX_C_W;

    localparam logic [ADDR_W-1:0] TBL_MASK = ~ADDR_W'(15);
    localparam logic [ADDR_W-1:0] PG_MASK  = ~ADDR_W'(255);

    logic [ADDR_W-1:0] idx_a, idx_b, idx_c;
    logic [ADDR_W-1:0] off_a, off_b, off_c;
    logic [ADDR_W-1:0] tbl_aligned, pg_aligned;

    // Scale indices by entry size and extract per-level offsets
    always_comb begin
        idx_a = ADDR_W'(va[ADDR_W-1:A_LO]) << 3;
        idx_b = ADDR_W'(va[A_LO-1:B_LO]) << 2;
        idx_c = ADDR_W'(va[B_LO-1:C_LO]) << 2;
        off_a = ADDR_W'(va[A_LO-1:0]);
        off_b = ADDR_W'(va[B_LO-1:0]);
        off_c = ADDR_W'(va[C_LO-1:0]);
        tbl_aligned = tbl_base & TBL_MASK;
        pg_aligned  = pg_base & PG_MASK;
    end

    // Select entry address by level being fetched
    always_comb begin
        case (ent_lvl)
            LVL_A:   ent_addr = tbl_aligned + idx_a;
            LVL_B:   ent_addr = tbl_aligned + idx_b;
            default: ent_addr = tbl_aligned + idx_c;
        endcase
    end

    // Select physical address by level at which the page was found
    always_comb begin
        case (pg_lvl)
            LVL_A:   page_addr = pg_aligned + off_a;
            LVL_B:   page_addr = pg_aligned + off_b;
            default: page_addr = pg_aligned + off_c;
        endcase
    end

endmodule

// File: rtl/mmu_table_walker.sv
// Three-level descriptor table walker.
// Fetches a two-word level-A entry, then short level-B and level-C entries.
// It stops early on a page, writes used/modified bits back, and reports faults.
// Assumes a memory port that holds each access until mem_ack, one access at a time.
module mmu_table_walker
    import mmu_walk_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IDX_A_W = 7,
    parameter int IDX_B_W = 7,
    parameter int IDX_C_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] root_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_super,
    output logic              resp_done,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic [1:0]        resp_fault,
    output logic              resp_ci,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack
);

    localparam logic [ADDR_W-1:0] HI_WORD_OFS = ADDR_W'(4);

    walk_state_e       state_q;
    level_e            lvl_q;
    logic [ADDR_W-1:0] va_q;
    logic [ADDR_W-1:0] ent_addr_q;
    logic [ADDR_W-1:0] base_q;
    logic [31:0]       attr0_q;
    logic [31:0]       wb_word_q;
    logic              wr_q, sv_q, page_q, ci_q;

    logic              done_q;
    logic [ADDR_W-1:0] paddr_q;
    logic [1:0]        fault_q;
    logic              rci_q;

    logic [31:0]       dec_attr;
    result_e           dec_res;
    fault_e            dec_flt;
    logic              dec_wb;
    logic [31:0]       dec_word;
    logic              dec_ci;

    level_e            next_lvl;
    level_e            gen_lvl;
    logic [ADDR_W-1:0] gen_base;
    logic [ADDR_W-1:0] gen_va;
    logic [ADDR_W-1:0] gen_ent_addr;
    logic [ADDR_W-1:0] gen_page_addr;

    // Choose decoder input and address generator operands from walk state
    always_comb begin
        dec_attr = (state_q == ST_RD_A1) ? attr0_q : mem_rdata;
        next_lvl = (lvl_q == LVL_A) ? LVL_B : LVL_C;
        gen_lvl  = (state_q == ST_IDLE) ? LVL_A : next_lvl;
        gen_base = (state_q == ST_IDLE) ? root_base : base_q;
        gen_va   = (state_q == ST_IDLE) ? req_vaddr : va_q;
    end

    mmu_desc_decode u_decode (
        .attr     (dec_attr),
        .lvl      (lvl_q),
        .is_write (wr_q),
        .is_super (sv_q),
        .res      (dec_res),
        .flt      (dec_flt),
        .need_wb  (dec_wb),
        .wb_word  (dec_word),
        .ci       (dec_ci)
    );

    mmu_addr_gen #(
        .ADDR_W  (ADDR_W),
        .IDX_A_W (IDX_A_W),
        .IDX_B_W (IDX_B_W),
        .IDX_C_W (IDX_C_W)
    ) u_addr (
        .ent_lvl   (gen_lvl),
        .tbl_base  (gen_base),
        .va        (gen_va),
        .pg_lvl    (lvl_q),
        .pg_base   (base_q),
        .ent_addr  (gen_ent_addr),
        .page_addr (gen_page_addr)
    );

    // Walk sequencer: fetch, decide, write back, advance or finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            lvl_q      <= LVL_A;
            va_q       <= '0;
            ent_addr_q <= '0;
            base_q     <= '0;
            attr0_q    <= '0;
            wb_word_q  <= '0;
            wr_q       <= 1'b0;
            sv_q       <= 1'b0;
            page_q     <= 1'b0;
            ci_q       <= 1'b0;
            done_q     <= 1'b0;
            paddr_q    <= '0;
            fault_q    <= FLT_NONE;
            rci_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q       <= req_vaddr;
                        wr_q       <= req_write;
                        sv_q       <= req_super;
                        lvl_q      <= LVL_A;
                        ent_addr_q <= gen_ent_addr;
                        state_q    <= ST_RD_A0;
                    end
                end
                ST_RD_A0: begin
                    if (mem_ack) begin
                        attr0_q <= mem_rdata;
                        state_q <= ST_RD_A1;
                    end
                end
                ST_RD_A1, ST_RD_SHORT: begin
                    if (mem_ack) begin
                        base_q    <= mem_rdata;
                        page_q    <= (dec_res == RES_PAGE);
                        ci_q      <= dec_ci;
                        wb_word_q <= dec_word;
                        if (dec_res == RES_FAULT) begin
                            done_q  <= 1'b1;
                            fault_q <= dec_flt;
                            paddr_q <= '0;
                            rci_q   <= 1'b0;
                            state_q <= ST_IDLE;
                        end else if (dec_wb) begin
                            state_q <= ST_WRBACK;
                        end else begin
                            state_q <= ST_ADVANCE;
                        end
                    end
                end
                ST_WRBACK: begin
                    if (mem_ack) state_q <= ST_ADVANCE;
                end
                ST_ADVANCE: begin
                    if (page_q) begin
                        done_q  <= 1'b1;
                        fault_q <= FLT_NONE;
                        paddr_q <= gen_page_addr;
                        rci_q   <= ci_q;
                        state_q <= ST_IDLE;
                    end else begin
                        lvl_q      <= next_lvl;
                        ent_addr_q <= gen_ent_addr;
                        state_q    <= ST_RD_SHORT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive memory port and response outputs from registered state
    always_comb begin
        mem_req    = (state_q != ST_IDLE) && (state_q != ST_ADVANCE);
        mem_we     = (state_q == ST_WRBACK);
        mem_addr   = (state_q == ST_RD_A1) ? ent_addr_q + HI_WORD_OFS : ent_addr_q;
        mem_wdata  = wb_word_q;
        req_ready  = (state_q == ST_IDLE);
        resp_done  = done_q;
        resp_paddr = paddr_q;
        resp_fault = fault_q;
        resp_ci    = rci_q;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !resp_done)); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R12

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done); // R12

    AST_WB_SETS_USED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[POS_USED]); // R9

    AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_done && (resp_fault != 2'b00)) |-> ((resp_paddr == '0) && !resp_ci)); // R6

endmodule

// File: tb/mmu_table_walker_test.sv
module mmu_table_walker_test;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 1024;
    localparam int NVEC       = 13;

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        sv;
        logic [31:0] pa;
        logic [1:0]  flt;
        logic        ci;
        logic [3:0]  rds;
        logic [3:0]  rq;
    } vec_t;

    // va, write, super, expected paddr, fault, ci, reads, requirement
    localparam vec_t VEC [NVEC] = '{
        '{32'h02083ABC, 1'b0, 1'b0, 32'h12345ABC, 2'd0, 1'b0, 4'd4, 4'd3},  // R3 full walk
        '{32'h04123456, 1'b0, 1'b0, 32'h40123456, 2'd0, 1'b1, 4'd2, 4'd4},  // R4 level-A page
        '{32'h06152345, 1'b0, 1'b1, 32'h50012345, 2'd0, 1'b0, 4'd3, 4'd5},  // R5 level-B page
        '{32'h08000000, 1'b0, 1'b0, 32'h00000000, 2'd1, 1'b0, 4'd2, 4'd6},  // R6 type 00 at A
        '{32'h0A000000, 1'b0, 1'b0, 32'h00000000, 2'd1, 1'b0, 4'd2, 4'd6},  // R6 type 11 at A
        '{32'h02180000, 1'b0, 1'b0, 32'h00000000, 2'd1, 1'b0, 4'd4, 4'd6},  // R6 table at C
        '{32'h0C083010, 1'b0, 1'b0, 32'h00000000, 2'd3, 1'b0, 4'd2, 4'd8},  // R8 user on supervisor entry
        '{32'h0C083010, 1'b0, 1'b1, 32'h12345010, 2'd0, 1'b0, 4'd4, 4'd8},  // R8 supervisor allowed
        '{32'h0E083020, 1'b1, 1'b1, 32'h00000000, 2'd2, 1'b0, 4'd2, 4'd7},  // R7 write on WP at A
        '{32'h0E083020, 1'b0, 1'b0, 32'h12345020, 2'd0, 1'b0, 4'd4, 4'd7},  // R7 read ignores WP
        '{32'h10000000, 1'b1, 1'b0, 32'h00000000, 2'd3, 1'b0, 4'd2, 4'd8},  // R8 priv beats WP
        '{32'h021C1044, 1'b1, 1'b0, 32'h00000000, 2'd2, 1'b0, 4'd4, 4'd7},  // R7 write on WP at C
        '{32'h021C1044, 1'b0, 1'b0, 32'h70000044, 2'd0, 1'b0, 4'd4, 4'd7}   // R7 read through WP at C
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_base = 32'h0000_0007;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_super = 1'b0;
    logic        resp_done;
    logic [31:0] resp_paddr;
    logic [1:0]  resp_fault;
    logic        resp_ci;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    logic [31:0] mem [MEM_WORDS];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic        first_pending = 1'b0;
    logic [31:0] first_addr = '0;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_table_walker uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .root_base  (root_base),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .req_write  (req_write),
        .req_super  (req_super),
        .resp_done  (resp_done),
        .resp_paddr (resp_paddr),
        .resp_fault (resp_fault),
        .resp_ci    (resp_ci),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack)
    );

    // Behavioural memory: one-cycle acknowledge, counts reads and writes
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack       <= 1'b0;
            first_pending <= 1'b0;
        end else begin
            if (req_valid && req_ready) first_pending <= 1'b1;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[11:2]] = mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    mem_rdata <= mem[mem_addr[11:2]];
                    rd_cnt    <= rd_cnt + 1;
                    if (first_pending) begin
                        first_addr    <= mem_addr;
                        first_pending <= 1'b0;
                    end
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input int byte_addr, input logic [31:0] val);
        mem[byte_addr >> 2] = val;
    endtask

    task automatic load_tables();
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
        put(12'h008, 32'h0000_0002); put(12'h00C, 32'h0000_0400);  // A1 -> B @0x400
        put(12'h010, 32'h0000_0049); put(12'h014, 32'h4000_0000);  // A2 page, CI
        put(12'h018, 32'h0000_000A); put(12'h01C, 32'h0000_0600);  // A3 -> B @0x600
        put(12'h028, 32'h0000_0003); put(12'h02C, 32'h0000_0400);  // A5 type 11
        put(12'h030, 32'h0000_010A); put(12'h034, 32'h0000_0400);  // A6 supervisor
        put(12'h038, 32'h0000_000E); put(12'h03C, 32'h0000_0400);  // A7 WP
        put(12'h040, 32'h0000_010E); put(12'h044, 32'h0000_0400);  // A8 super + WP
        put(12'h048, 32'h0000_0002); put(12'h04C, 32'h0000_0B00);  // A9 fresh chain
        put(12'h050, 32'h0000_0106); put(12'h054, 32'h0000_0400);  // A10 super+WP, used clear
        put(12'h408, 32'h0000_0802);                               // B2 -> C @0x800
        put(12'h418, 32'h0000_0902);                               // B6 -> C @0x900
        put(12'h41C, 32'h0000_0A0A);                               // B7 -> C @0xA00
        put(12'h614, 32'h5000_0009);                               // B page
        put(12'h80C, 32'h1234_5001);                               // C page
        put(12'h900, 32'h0000_000A);                               // table type at level C
        put(12'hA04, 32'h7000_000D);                               // C page with WP
        put(12'hB00, 32'h0000_0C02);                               // fresh B -> C @0xC00
        put(12'hC00, 32'h6000_0001);                               // fresh C page
    endtask

    // Issue one request, wait for the done pulse, capture results and counts
    task automatic walk(input logic [31:0] va, input logic wr, input logic sv,
                        output logic [31:0] pa, output logic [1:0] flt, output logic ci,
                        output int reads, output int writes, output logic pulse_ok);
        int r0;
        int w0;
        int guard;
        r0 = rd_cnt;
        w0 = wr_cnt;
        guard = 0;
        req_vaddr = va;
        req_write = wr;
        req_super = sv;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        pa  = resp_paddr;
        flt = resp_fault;
        ci  = resp_ci;
        @(negedge clk);
        pulse_ok = (guard < 200) && !resp_done;
        reads  = rd_cnt - r0;
        writes = wr_cnt - w0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] pa;
        logic [1:0]  flt;
        logic        ci;
        int          rds;
        int          wrs;
        logic        pok;

        load_tables();
        repeat (4) @(negedge clk);
        check("R1 done low in reset", {31'd0, resp_done}, 32'd0);
        check("R1 mem_req low in reset", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        check("R1 done low after reset", {31'd0, resp_done}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            walk(VEC[i].va, VEC[i].wr, VEC[i].sv, pa, flt, ci, rds, wrs, pok);
            check($sformatf("R%0d vec%0d paddr", VEC[i].rq, i), pa, VEC[i].pa);
            check($sformatf("R%0d vec%0d fault", VEC[i].rq, i), {30'd0, flt}, {30'd0, VEC[i].flt});
            check($sformatf("R%0d vec%0d ci", VEC[i].rq, i), {31'd0, ci}, {31'd0, VEC[i].ci});
            check($sformatf("R%0d vec%0d reads", VEC[i].rq, i), rds, {28'd0, VEC[i].rds});
            check($sformatf("R2 vec%0d first fetch addr", i), first_addr, {VEC[i].va[31:25], 3'b000});
            check($sformatf("R12 vec%0d single done pulse", i), {31'd0, pok}, 32'd1);
        end

        // R9: used bits written back along earlier read walks
        check("R9 level-A word0 used set", mem[12'h008 >> 2], 32'h0000_000A);
        check("R9 level-A word1 untouched", mem[12'h00C >> 2], 32'h0000_0400);
        check("R9 level-B used set", mem[12'h408 >> 2], 32'h0000_080A);
        check("R9 level-B set before C fault", mem[12'h418 >> 2], 32'h0000_090A);
        // R10: read accesses leave the modified bit clear
        check("R10 read keeps M clear", mem[12'h80C >> 2], 32'h1234_5009);

        // R11: faulting descriptor with used clear is not written
        walk(32'h1400_0000, 1'b1, 1'b0, pa, flt, ci, rds, wrs, pok);
        check("R11 fault code", {30'd0, flt}, 32'd3);
        check("R11 no write-back", wrs, 32'd0);
        check("R11 word unchanged", mem[12'h050 >> 2], 32'h0000_0106);

        // R10: write through a fresh chain sets U and M in one write per level
        walk(32'h1200_0005, 1'b1, 1'b0, pa, flt, ci, rds, wrs, pok);
        check("R10 paddr", pa, 32'h6000_0005);
        check("R10 fault", {30'd0, flt}, 32'd0);
        check("R10 three write-backs", wrs, 32'd3);
        check("R10 page U and M set", mem[12'hC00 >> 2], 32'h6000_0019);
        check("R9 fresh level-A used", mem[12'h048 >> 2], 32'h0000_000A);
        check("R9 fresh level-B used", mem[12'hB00 >> 2], 32'h0000_0C0A);

        // R9: repeat walk finds every bit set and writes nothing
        walk(32'h1200_0005, 1'b1, 1'b0, pa, flt, ci, rds, wrs, pok);
        check("R9 no write when bits set", wrs, 32'd0);
        check("R3 repeat paddr", pa, 32'h6000_0005);

        // R10: write on a page already used but not modified: one write sets M
        walk(32'h0208_3ABC, 1'b1, 1'b0, pa, flt, ci, rds, wrs, pok);
        check("R10 single write sets M", wrs, 32'd1);
        check("R10 page word", mem[12'h80C >> 2], 32'h1234_5019);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule